// File: doc/BRIEF.md
# Strobed Parallel Capture with SPI Echo

A host processor places one byte on eight parallel lines and then raises a trigger line. The block grabs the byte on the trigger's rising edge and keeps it. On the next SPI transaction, the kept byte is shifted out on MISO. The host can then compare the byte it wrote with the byte it read back. This makes the block a loopback probe for a host-to-logic link, and it confirms that both paths work before any real data path is built on them.

All host inputs are asynchronous to the system clock. Each one passes through a two-flop synchroniser before any edge is detected. The transmit shift register has a single clocked writer, which chooses its source by priority:

- a parallel load from the held byte;
- otherwise a one-bit shift that takes in the bit last sampled from MOSI.

A capture that arrives while chip select is active is kept pending. It reaches the shift register only after chip select is released, so a byte that is being transferred is never disturbed.

Top module: `strobe_echo_spi`

## Requirements
- R1: After reset, MISO is 0 and the transmit register holds 0x00, so the first transfer returns 0x00.
- R2: A rising edge on `trigIn` captures `parData`, and the next SPI transfer returns that byte with bit 7 first. Inputs must stay stable for at least 3 clock cycles around each change.
- R3: A falling edge on `trigIn`, or a change on `parData` while no rising edge occurs, does not alter the byte that is returned.
- R4: SPI mode 0 is used. The first bit (bit 7) is on MISO once `csN` has been low for 3 clock cycles. MISO holds its value while SCK is high and moves to the next lower bit only after a falling SCK edge.
- R5: MOSI is sampled on each rising SCK edge, and that bit enters the register's LSB at the following falling edge. After a full 8-bit transfer with no capture, the next transfer returns the byte that was sent on MOSI.
- R6: A capture made while `csN` is low does not change the transfer in progress. The capture is applied after `csN` goes high, and the next transfer returns it. A load and a shift never happen in the same cycle.
- R7: MISO is driven 0 whenever `csN` is high.
- R8: A transfer cut short after N bits leaves the register shifted left by N, with the N MOSI bits in its low end. The next transfer returns that value.
- R9: Each capture replaces the previously held byte. With two captures and no transfer between them, the later one is returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| parData | input | 8 | Parallel byte from the host |
| trigIn | input | 1 | Capture trigger, rising-edge active |
| sck | input | 1 | SPI serial clock, idles low |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from the host |
| miso | output | 1 | SPI data to the host |

## Verification
Single-bit, all-ones, all-zeros and mixed bytes are captured and read back. These patterns tell a correct MSB-first order apart from a reversed or stuck bit. After each capture, the bench sends the inverted byte on MOSI and expects it back on the following transfer. This separates the MOSI shift-in path from the parallel load. Other cases cover:

- a data change with no trigger edge;
- a capture made in the middle of a transfer;
- a transfer aborted after three bits;
- two captures in a row.

Each of these distinguishes a different priority or timing choice of the register's single writer.

// File: rtl/strobe_echo_pkg.sv
package strobe_echo_pkg;
  // Strobes from control to datapath, at most one register write per cycle
  typedef struct packed {
    logic capture;  // latch parallel byte into hold register
    logic load;     // copy hold register into transmit register
    logic sample;   // take MOSI bit (rising SCK)
    logic shift;    // advance transmit register (falling SCK)
  } echoStrb_t;
endpackage

// File: rtl/strobe_echo_ctrl.sv
module strobe_echo_ctrl
  import strobe_echo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      trigIn,
  input  logic      sck,
  input  logic      csN,
  input  logic      mosi,
  output echoStrb_t strb,
  output logic      csActive,
  output logic      mosiS
);
  localparam int CHAIN = SYNC_STAGES + 1;  // one extra stage for edge detection
  localparam int NOW   = SYNC_STAGES - 1;
  localparam int OLD   = SYNC_STAGES;

  logic [CHAIN-1:0]       trigSh, sckSh, csSh;
  logic [SYNC_STAGES-1:0] mosiSh;
  logic                   pending;
  logic                   trigRise, sckRise, sckFall, loadNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigSh <= '0;
      sckSh  <= '0;
      csSh   <= '1;
      mosiSh <= '0;
    end else begin
      trigSh <= {trigSh[CHAIN-2:0], trigIn};
      sckSh  <= {sckSh[CHAIN-2:0], sck};
      csSh   <= {csSh[CHAIN-2:0], csN};
      mosiSh <= {mosiSh[SYNC_STAGES-2:0], mosi};
    end
  end

  assign trigRise = trigSh[NOW] & ~trigSh[OLD];
  assign sckRise  = sckSh[NOW] & ~sckSh[OLD];
  assign sckFall  = ~sckSh[NOW] & sckSh[OLD];
  assign csActive = ~csSh[NOW];
  assign mosiS    = mosiSh[NOW];
  assign loadNow  = pending & ~csActive;

  // capture held back until the bus is idle; a new capture re-arms it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pending <= 1'b0;
    else       pending <= trigRise | (pending & ~loadNow);
  end

  always_comb begin
    strb.capture = trigRise;
    strb.load    = loadNow;
    strb.sample  = sckRise & csActive;
    strb.shift   = sckFall & csActive;
  end
endmodule

// File: rtl/strobe_echo_dpath.sv
module strobe_echo_dpath
  import strobe_echo_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] parData,
  input  logic              mosiS,
  input  logic              csActive,
  input  echoStrb_t         strb,
  output logic [DATA_W-1:0] shData,
  output logic              miso
);
  localparam int MSB = DATA_W - 1;

  logic [SYNC_STAGES-1:0][DATA_W-1:0] dataSh;
  logic [DATA_W-1:0]                  holdReg, shReg;
  logic                               mosiBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataSh  <= '0;
      holdReg <= '0;
      mosiBit <= 1'b0;
    end else begin
      dataSh <= {dataSh[SYNC_STAGES-2:0], parData};
      if (strb.capture) holdReg <= dataSh[SYNC_STAGES-1];
      if (strb.sample)  mosiBit <= mosiS;
    end
  end

  // sole writer of the transmit register: parallel load beats shifting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           shReg <= '0;
    else if (strb.load)  shReg <= holdReg;
    else if (strb.shift) shReg <= {shReg[MSB-1:0], mosiBit};
  end

  assign shData = shReg;
  assign miso   = csActive & shReg[MSB];
endmodule

// File: rtl/strobe_echo_spi.sv
module strobe_echo_spi
  import strobe_echo_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] parData,
  input  logic              trigIn,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  output logic              miso
);
  echoStrb_t         strb;
  logic              csActive, mosiS;
  logic [DATA_W-1:0] shData;

  strobe_echo_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .sck(sck), .csN(csN),
    .mosi(mosi), .strb(strb), .csActive(csActive), .mosiS(mosiS)
  );

  strobe_echo_dpath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uDpath (
    .clk(clk), .rstN(rstN), .parData(parData), .mosiS(mosiS),
    .csActive(csActive), .strb(strb), .shData(shData), .miso(miso)
  );
endmodule

// File: rtl/strobe_echo_chk.sv
module strobe_echo_chk
  import strobe_echo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              miso,
  input logic              csActive,
  input echoStrb_t         strb,
  input logic [DATA_W-1:0] shData
);
  AST_IDLE_MISO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2)) |-> !miso);  // R7

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.load, strb.shift, strb.sample}));  // R6

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !csActive);  // R6

  AST_REG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.shift) |=> $stable(shData));  // R3

  AST_MISO_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (csActive && $past(csActive) && !$past(strb.load) && !$past(strb.shift))
      |-> $stable(miso));  // R4
endmodule

bind strobe_echo_spi strobe_echo_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .miso(miso),
  .csActive(csActive), .strb(strb), .shData(shData)
);

// File: tb/strobe_echo_spi_test.sv
module strobe_echo_spi_test;
  logic       clk = 1'b0, rstN = 1'b0, trigIn = 1'b0, sck = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic [7:0] parData = 8'h00;
  logic       miso;

  always #10 clk = ~clk;  // 50 MHz

  strobe_echo_spi uut (
    .clk(clk), .rstN(rstN), .parData(parData), .trigIn(trigIn),
    .sck(sck), .csN(csN), .mosi(mosi), .miso(miso)
  );

  int         nCmp = 0, nBad = 0;
  bit         done = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [7:0] rxQ[$];

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expectByte(input string tag, input logic [7:0] b);
    expQ.push_back(b);
    tagQ.push_back(tag);
  endtask

  task automatic capture(input logic [7:0] b);
    parData = b;
    waitClk(4);
    trigIn = 1'b1;
    waitClk(6);
    trigIn = 1'b0;
    waitClk(4);
  endtask

  // mode 0 master: sample MISO just before each rising SCK edge
  task automatic spiXfer(input logic [7:0] tx, input int nBits, input bit midCap,
                         input logic [7:0] capB, input bit keep);
    logic [7:0] rx = 8'h00;
    csN = 1'b0;
    waitClk(6);
    for (int i = 0; i < nBits; i++) begin
      mosi = tx[7-i];
      waitClk(4);
      rx[7-i] = miso;
      sck = 1'b1;
      waitClk(8);
      sck = 1'b0;
      waitClk(4);
      if (midCap && i == 3) capture(capB);
    end
    csN = 1'b1;
    waitClk(6);
    if (keep) rxQ.push_back(rx);
  endtask

  // monitor: pop results and compare them with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (rxQ.size() > 0) begin
        logic [7:0] got, want;
        string      tag;
        got = rxQ.pop_front();
        if (expQ.size() == 0) begin
          nCmp++;
          nBad++;
          $display("FAIL unexpected readback: actual %h expected none", got);
        end else begin
          want = expQ.pop_front();
          tag  = tagQ.pop_front();
          check(tag, got, want);
        end
      end
    end
  end

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    waitClk(150000);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0] pats[5] = '{8'h80, 8'h01, 8'hFF, 8'h00, 8'h69};
    waitClk(3);
    check("R1 miso in reset", {7'b0, miso}, 8'h00);
    rstN = 1'b1;
    waitClk(3);
    check("R1 miso after reset", {7'b0, miso}, 8'h00);

    expectByte("R1 first transfer", 8'h00);
    spiXfer(8'hC3, 8, 1'b0, 8'h00, 1'b1);
    expectByte("R5 mosi echo", 8'hC3);
    spiXfer(8'h00, 8, 1'b0, 8'h00, 1'b1);

    capture(8'hA5);
    expectByte("R2 capture A5", 8'hA5);
    spiXfer(8'h3C, 8, 1'b0, 8'h00, 1'b1);
    expectByte("R5 mosi echo 3C", 8'h3C);
    spiXfer(8'h00, 8, 1'b0, 8'h00, 1'b1);

    foreach (pats[k]) begin
      capture(pats[k]);
      expectByte("R2 pattern", pats[k]);
      spiXfer(~pats[k], 8, 1'b0, 8'h00, 1'b1);
      expectByte("R5 inverted echo", ~pats[k]);
      spiXfer(8'h00, 8, 1'b0, 8'h00, 1'b1);
    end

    // R3: data changes while trigger stays high, then trigger falls
    parData = 8'h5A;
    waitClk(4);
    trigIn = 1'b1;
    waitClk(6);
    parData = 8'hFF;
    waitClk(6);
    trigIn = 1'b0;
    parData = 8'h0F;
    waitClk(6);
    expectByte("R3 no retrigger", 8'h5A);
    spiXfer(8'hE7, 8, 1'b0, 8'h00, 1'b1);

    // R8: cut after 3 bits: {E7[4:0], 101} = 3D
    spiXfer(8'hA0, 3, 1'b0, 8'h00, 1'b0);
    expectByte("R8 partial shift", 8'h3D);
    spiXfer(8'h00, 8, 1'b0, 8'h00, 1'b1);

    // R6: capture of 9C during a transfer of register 00
    expectByte("R6 in-flight untouched", 8'h00);
    spiXfer(8'h55, 8, 1'b1, 8'h9C, 1'b1);
    expectByte("R6 pending applied", 8'h9C);
    spiXfer(8'h00, 8, 1'b0, 8'h00, 1'b1);

    capture(8'h11);
    capture(8'h22);
    expectByte("R9 latest wins", 8'h22);
    spiXfer(8'h00, 8, 1'b0, 8'h00, 1'b1);

    capture(8'hFF);
    for (int i = 0; i < 4; i++) begin
      waitClk(3);
      check("R7 idle miso", {7'b0, miso}, 8'h00);
    end

    capture(8'h7F);
    csN = 1'b0;
    waitClk(6);
    check("R4 first bit", {7'b0, miso}, 8'h00);
    sck = 1'b1;
    waitClk(8);
    check("R4 held while sck high", {7'b0, miso}, 8'h00);
    sck = 1'b0;
    waitClk(6);
    check("R4 next bit after fall", {7'b0, miso}, 8'h01);
    csN = 1'b1;
    waitClk(6);

    while (expQ.size() > 0 || rxQ.size() > 0) waitClk(1);
    waitClk(2);
    done = 1'b1;
    report();
  end
endmodule